// File: doc/BRIEF.md
# Dual-Mode Converter Control Register Interface

This block is the host-facing slave that holds the control registers of a data converter. A host writes 12-bit words. The two top bits select the target register: prefix `00` loads a plain 10-bit register 0, and prefix `01` loads the fields of register 1. Reads return data supplied by a neighbouring FIFO block, except during a debug readback sequence that returns the two registers one after the other.

The host can use one of two strobe conventions, chosen at run time by a bit of register 1. In split-strobe mode, the read strobe and the write strobe are separate pins. In direction mode, the read-strobe pin is ignored and the write pin states the direction of an access framed by chip select. A write takes effect in the cycle after its strobe ends. Two register-1 bits are commands that clear themselves: a soft reset and a FIFO flush.

Top module: `conv_host_regif`

## Requirements
- R1: After `rst_ni` is asserted, register 0 reads 0. Register 1 has polarity 1, pulse type 1 and every other field 0. `data_oe_o`, `fifo_rd_o`, `soft_rst_o` and `fifo_rst_o` are 0.
- R2: A write whose bits 11:10 are `00` stores bits 9:0 unchanged in register 0 (`ctrl0_o`).
- R3: A write whose bits 11:10 are `01` and whose bit 0 is 0 loads register 1 with this layout: bit 9 readback enable, bit 8 offset calibrate, bit 7 binary format, bit 6 direction mode, bit 5 availability polarity, bit 4 availability pulse type, bits 3:2 trigger level.
- R4: A write whose bits 11:10 are `10` or `11` changes no register and raises no command pulse.
- R5: Register outputs keep their values while a write strobe is held. A write's value appears on the outputs in the first cycle after the last cycle in which the strobe was active.
- R6: While `cs_n_i` is high, no write is taken, `data_oe_o` stays 0 and no FIFO read is counted.
- R7: With direction mode 0, `rd_n_i` low together with `cs_n_i` low is a read: `data_oe_o` is 1. `wr_n_i` low together with `cs_n_i` low is a write.
- R8: With direction mode 1, `rd_n_i` is ignored. With `cs_n_i` low, `wr_n_i` high is a read (`data_oe_o` is 1) and `wr_n_i` low is a write (`data_oe_o` is 0).
- R9: After a register-1 write with bit 9 set, the first completed read returns `{2'b00, ctrl0}` and the second returns `{2'b01, register 1 bits 9:2, 2'b00}`. Later reads return FIFO data until register 1 is written again with bit 9 set. Readback reads do not pulse `fifo_rd_o`.
- R10: A register-1 write with bit 0 set returns both registers to their R1 values and clears the readback sequence. It also drives `soft_rst_o` high for exactly one cycle.
- R11: A register-1 write with bit 1 set drives `fifo_rst_o` high for exactly one cycle, and its other fields load as in R3.
- R12: Outside readback, a read returns `fifo_data_i` on `data_o`. `fifo_rd_o` pulses for exactly one cycle after each such read strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe in split mode, active low |
| wr_n_i | input | 1 | Write strobe (split mode) or direction, high = read (direction mode) |
| data_i | input | 12 | Write data from the host bus |
| fifo_data_i | input | 12 | Sample word offered by the FIFO block |
| data_o | output | 12 | Read data toward the host bus |
| data_oe_o | output | 1 | Drive enable for the bus pads |
| fifo_rd_o | output | 1 | One-cycle pop request to the FIFO |
| ctrl0_o | output | 10 | Register 0 contents |
| rback_en_o | output | 1 | Readback enable |
| ofs_cal_o | output | 1 | Offset calibrate request |
| bin_fmt_o | output | 1 | Binary output format select |
| rw_mode_o | output | 1 | Direction-mode select |
| av_pol_o | output | 1 | Availability signal polarity |
| av_pulse_o | output | 1 | Availability signal pulse type |
| trig_lvl_o | output | 2 | FIFO trigger level |
| fifo_rst_o | output | 1 | One-cycle FIFO flush command |
| soft_rst_o | output | 1 | One-cycle soft reset command |

## Verification
A corrupted strobe edge detector shows up as a register update one cycle early, while the strobe is still held. It also shows up as a missing or doubled FIFO pop in the cycle after a read ends. A wrong readback state shows up on the first or second read data word after arming, or as a pop during a readback read. A command bit that fails to self-clear shows up as a pulse still high one cycle after the write lands. A wrong reset value shows up on the field outputs as soon as reset, or a soft reset, completes.

// File: rtl/conv_regif_pkg.sv
package conv_regif_pkg;
  localparam int unsigned SEL_W = 2;

  typedef struct packed {
    logic       rback;
    logic       ofs_cal;
    logic       bin_fmt;
    logic       rw_mode;
    logic       av_pol;
    logic       av_pulse;
    logic [1:0] trig;
  } ctrl1_t;

  localparam ctrl1_t CTRL1_RST = '{rback: 1'b0, ofs_cal: 1'b0, bin_fmt: 1'b0,
                                   rw_mode: 1'b0, av_pol: 1'b1, av_pulse: 1'b1,
                                   trig: 2'b00};

  localparam logic [SEL_W-1:0] SEL_R0 = 2'b00;
  localparam logic [SEL_W-1:0] SEL_R1 = 2'b01;

  typedef enum logic [1:0] {RB_IDLE, RB_REG0, RB_REG1} rb_state_e;
endpackage

// File: rtl/regif_strobe.sv
module regif_strobe #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              rw_mode_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_act_o,
  output logic              rd_done_o,
  output logic              wr_commit_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic rd_q, wr_q, wr_act;
  logic [DATA_W-1:0] wdata_q;

  // direction mode: rd_n ignored, wr_n is the direction line
  assign rd_act_o = !cs_n_i && (rw_mode_i ? wr_n_i : !rd_n_i);
  assign wr_act   = !cs_n_i && !wr_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      rd_q <= rd_act_o;
      wr_q <= wr_act;
      if (wr_act) wdata_q <= data_i;
    end
  end

  assign wr_commit_o = wr_q && !wr_act;
  assign rd_done_o   = rd_q && !rd_act_o;
  assign wdata_o     = wdata_q;

  p_commit_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o);
  p_rd_done_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !rd_done_o);
endmodule

// File: rtl/regif_regs.sv
module regif_regs
  import conv_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  localparam int unsigned R0_W = DATA_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [R0_W-1:0]   ctrl0_o,
  output ctrl1_t            ctrl1_o,
  output logic              soft_rst_o,
  output logic              fifo_rst_o,
  output logic              rb_arm_o,
  output logic              rb_clr_o
);
  logic [R0_W-1:0] r0_q;
  ctrl1_t          r1_q;
  logic            soft_q, flush_q;
  logic            is_r0, is_r1;
  logic [SEL_W-1:0] sel;

  assign sel   = wdata_i[DATA_W-1 -: SEL_W];
  assign is_r0 = commit_i && (sel == SEL_R0);
  assign is_r1 = commit_i && (sel == SEL_R1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0_q    <= '0;
      r1_q    <= CTRL1_RST;
      soft_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      soft_q  <= 1'b0;
      flush_q <= 1'b0;
      if (is_r1 && wdata_i[0]) begin
        r0_q   <= '0;
        r1_q   <= CTRL1_RST;
        soft_q <= 1'b1;
      end else if (is_r1) begin
        r1_q    <= ctrl1_t'(wdata_i[R0_W-1:2]);
        flush_q <= wdata_i[1];
      end else if (is_r0) begin
        r0_q <= wdata_i[R0_W-1:0];
      end
    end
  end

  assign rb_arm_o   = is_r1 && !wdata_i[0] && wdata_i[R0_W-1];
  assign rb_clr_o   = is_r1 && (wdata_i[0] || !wdata_i[R0_W-1]);
  assign ctrl0_o    = r0_q;
  assign ctrl1_o    = r1_q;
  assign soft_rst_o = soft_q;
  assign fifo_rst_o = flush_q;

  p_hold_no_commit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(r0_q) && $stable(r1_q)));
  p_soft_rst_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);
  p_soft_rst_values_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (ctrl0_o == '0 && ctrl1_o == CTRL1_RST));
  p_flush_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rst_o |=> !fifo_rst_o);
  p_cmds_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(soft_rst_o && fifo_rst_o));
endmodule

// File: rtl/regif_rdmux.sv
module regif_rdmux
  import conv_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  localparam int unsigned R0_W = DATA_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              clr_i,
  input  logic              rd_done_i,
  input  logic [R0_W-1:0]   ctrl0_i,
  input  ctrl1_t            ctrl1_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fifo_rd_o
);
  rb_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RB_IDLE;
    end else if (clr_i) begin
      state_q <= RB_IDLE;
    end else if (arm_i) begin
      state_q <= RB_REG0;
    end else if (rd_done_i) begin
      case (state_q)
        RB_REG0: state_q <= RB_REG1;
        RB_REG1: state_q <= RB_IDLE;
        default: state_q <= RB_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      RB_REG0: rdata_o = {SEL_R0, ctrl0_i};
      RB_REG1: rdata_o = {SEL_R1, ctrl1_i, 2'b00};
      default: rdata_o = fifo_data_i;
    endcase
  end

  assign fifo_rd_o = rd_done_i && (state_q == RB_IDLE);

  p_rb_order_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RB_REG1) |-> ($past(state_q) inside {RB_REG0, RB_REG1}));
  p_rb_no_pop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != RB_IDLE) |-> !fifo_rd_o);
  p_pop_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |=> !fifo_rd_o);
endmodule

// File: rtl/conv_host_regif.sv
module conv_host_regif
  import conv_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  localparam int unsigned R0_W = DATA_W - SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              fifo_rd_o,
  output logic [R0_W-1:0]   ctrl0_o,
  output logic              rback_en_o,
  output logic              ofs_cal_o,
  output logic              bin_fmt_o,
  output logic              rw_mode_o,
  output logic              av_pol_o,
  output logic              av_pulse_o,
  output logic [1:0]        trig_lvl_o,
  output logic              fifo_rst_o,
  output logic              soft_rst_o
);
  logic              rd_act, rd_done, wr_commit, rb_arm, rb_clr;
  logic [DATA_W-1:0] wdata;
  ctrl1_t            ctrl1;

  regif_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk_i, .rst_ni, .cs_n_i, .rd_n_i, .wr_n_i,
    .rw_mode_i  (ctrl1.rw_mode),
    .data_i,
    .rd_act_o   (rd_act),
    .rd_done_o  (rd_done),
    .wr_commit_o(wr_commit),
    .wdata_o    (wdata)
  );

  regif_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .commit_i  (wr_commit),
    .wdata_i   (wdata),
    .ctrl0_o,
    .ctrl1_o   (ctrl1),
    .soft_rst_o,
    .fifo_rst_o,
    .rb_arm_o  (rb_arm),
    .rb_clr_o  (rb_clr)
  );

  regif_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .clk_i, .rst_ni,
    .arm_i      (rb_arm),
    .clr_i      (rb_clr),
    .rd_done_i  (rd_done),
    .ctrl0_i    (ctrl0_o),
    .ctrl1_i    (ctrl1),
    .fifo_data_i,
    .rdata_o    (data_o),
    .fifo_rd_o
  );

  assign data_oe_o  = rd_act;
  assign rback_en_o = ctrl1.rback;
  assign ofs_cal_o  = ctrl1.ofs_cal;
  assign bin_fmt_o  = ctrl1.bin_fmt;
  assign rw_mode_o  = ctrl1.rw_mode;
  assign av_pol_o   = ctrl1.av_pol;
  assign av_pulse_o = ctrl1.av_pulse;
  assign trig_lvl_o = ctrl1.trig;

  p_oe_needs_cs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !cs_n_i);
  p_dir_write_no_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_mode_o && !cs_n_i && !wr_n_i) |-> !data_oe_o);
  p_pop_needs_prior_oe_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_rd_o |-> $past(data_oe_o));
endmodule

// File: tb/conv_host_regif_bench.sv
module conv_host_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [11:0] din = '0, fifo_val = 12'h000;
  logic [11:0] dout;
  logic        oe, pop, rback, ofs, bin, rwm, pol, pls, frst, srst;
  logic [9:0]  c0;
  logic [1:0]  trig;
  logic        mode_dir = 1'b0;
  int          checks = 0, fails = 0, pops = 0;

  always #5 clk = ~clk;

  conv_host_regif u_conv_host_regif (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .data_i(din), .fifo_data_i(fifo_val), .data_o(dout), .data_oe_o(oe),
    .fifo_rd_o(pop), .ctrl0_o(c0), .rback_en_o(rback), .ofs_cal_o(ofs),
    .bin_fmt_o(bin), .rw_mode_o(rwm), .av_pol_o(pol), .av_pulse_o(pls),
    .trig_lvl_o(trig), .fifo_rst_o(frst), .soft_rst_o(srst)
  );

  always @(posedge clk) if (rst_n && pop) pops++;

  function automatic logic [9:0] r1v();
    return {rback, ofs, bin, rwm, pol, pls, trig, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] w);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = w;
    @(negedge clk); @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(output logic [11:0] d, output logic e);
    @(negedge clk); cs_n = 1'b0;
    if (mode_dir) wr_n = 1'b1; else rd_n = 1'b0;
    @(negedge clk); d = dout; e = oe;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [11:0] d;
    logic e;
    int p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ctrl0", c0, 10'h000);
    chk("R1 ctrl1", r1v(), 10'h030);
    chk("R1 strobes", {oe, pop, srst, frst}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {c0, r1v()}, {10'h000, 10'h030});

    // R2 register 0 sweep
    for (int j = 0; j < 10; j++) begin
      wr(12'h000 | (12'h1 << j));
      chk("R2 walk", c0, 10'h1 << j);
    end
    wr(12'h155); chk("R2 pattern", c0, 10'h155);
    wr(12'h3FF); chk("R2 ones", c0, 10'h3FF);
    wr(12'h2AA); chk("R2 pattern", c0, 10'h2AA);

    // R3 register 1 field sweep (direction mode and readback kept 0)
    for (int i = 0; i < 64; i++) begin
      logic [11:0] w;
      w = 12'h400 | (12'(i >> 4) << 7) | (12'(i & 15) << 2);
      wr(w);
      chk("R3 fields", r1v(), w[9:0]);
      chk("R3 no cmd", {frst, srst}, 2'b00);
    end
    chk("R3 ctrl0 kept", c0, 10'h2AA);
    wr(12'h430);

    // R4 unused prefixes
    wr(12'h8FF); wr(12'hC00); wr(12'hBFD);
    chk("R4 ctrl0", c0, 10'h2AA);
    chk("R4 ctrl1", r1v(), 10'h030);

    // R5 no change while strobe held, visible one cycle after release
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; din = 12'h0C3;
    @(negedge clk); @(negedge clk);
    chk("R5 held", c0, 10'h2AA);
    cs_n = 1'b1; wr_n = 1'b1;
    chk("R5 edge cycle", c0, 10'h2AA);
    @(negedge clk);
    chk("R5 landed", c0, 10'h0C3);

    // R6 chip select gating
    @(negedge clk); wr_n = 1'b0; rd_n = 1'b0; din = 12'h011;
    @(negedge clk); chk("R6 no oe", oe, 1'b0);
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 no write", c0, 10'h0C3);
    chk("R6 no pop", pops, 0);

    // R7/R12 split-mode FIFO read
    fifo_val = 12'hA5C;
    rd(d, e);
    chk("R7 oe", e, 1'b1);
    chk("R12 data", d, 12'hA5C);
    chk("R12 one pop", pops, 1);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); chk("R7 cs only no oe", oe, 1'b0);
    cs_n = 1'b1;
    @(negedge clk);
    chk("R12 no pop w/o read", pops, 1);

    // R9 readback sequence
    wr(12'h0C3);
    wr(12'h6B0);
    fifo_val = 12'h3E7;
    rd(d, e); chk("R9 first reg0", d, 12'h0C3);
    rd(d, e); chk("R9 second reg1", d, 12'h6B0);
    chk("R9 no pops", pops, 1);
    rd(d, e); chk("R9 then fifo", d, 12'h3E7);
    chk("R9 fifo pop", pops, 2);
    wr(12'h6B0);
    rd(d, e); chk("R9 rearm reg0", d, 12'h0C3);

    // R8 direction mode
    wr(12'h470);
    mode_dir = 1'b1;
    chk("R8 mode on", rwm, 1'b1);
    fifo_val = 12'h123;
    p0 = pops;
    rd(d, e);
    chk("R8 dir read oe", e, 1'b1);
    chk("R8 dir read data", d, 12'h123);
    chk("R8 pop", pops, p0 + 1);
    @(negedge clk); cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; din = 12'h055;
    @(negedge clk); chk("R8 rd ignored, write no oe", oe, 1'b0);
    cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk("R8 dir write", c0, 10'h055);
    chk("R8 no pop on write", pops, p0 + 1);
    wr(12'h670);
    rd(d, e); chk("R8 dir readback r0", d, 12'h055);
    rd(d, e); chk("R8 dir readback r1", d, 12'h670);
    wr(12'h430);
    mode_dir = 1'b0;
    chk("R8 mode off", rwm, 1'b0);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); chk("R7 split wr_n high no oe", oe, 1'b0);
    cs_n = 1'b1;
    @(negedge clk);

    // R11 FIFO flush pulse
    wr(12'h48E);
    chk("R11 pulse", frst, 1'b1);
    chk("R11 fields", r1v(), 10'h08C);
    @(negedge clk);
    chk("R11 self clear", frst, 1'b0);

    // R10 soft reset
    wr(12'h2F0);
    wr(12'h6C8);
    wr(12'h7FD);
    chk("R10 pulse", srst, 1'b1);
    chk("R10 regs", {c0, r1v()}, {10'h000, 10'h030});
    @(negedge clk);
    chk("R10 self clear", srst, 1'b0);
    fifo_val = 12'h9A9;
    rd(d, e); chk("R10 readback cleared", d, 12'h9A9);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule